// File: doc/BRIEF.md
# Multicycle 8-bit Processor Core

This block is a small 8-bit processor that runs each instruction over several clock cycles, reusing one adder/logic unit and one byte-wide memory for every step. Instructions and data share a 256-byte internal array. Intermediate results sit in holding registers: an instruction register, a memory data register, two operand registers and an ALU result register. A 4-bit state register, stepped by a controller, sequences fetch, decode and the steps of each instruction. The program counter increment and the branch-target addition are also done by the shared ALU.

Before a run, the surrounding logic writes the program and data into the array through a simple write port while reset is held. After reset is released the core starts at address 0x80. Debug outputs show the controller state, the PC, all four general registers, the two condition flags and a pulse that marks the last cycle of each instruction. A cycle-accurate test can use them to count cycles per instruction.

Every instruction is one byte. In register-register forms, bits [7:6] name the destination/first register (rx), bits [5:4] name the second register (ry), and bits [3:0] hold the opcode.

Top module: `mc8_core`

## Requirements
- R1: While rst_n is low, the PC becomes 0x80, r0..r3 and both flags become 0 and the state output becomes 0 (fetch). The state output only takes the codes 0 to 11.
- R2: Every instruction starts with a fetch cycle. That cycle loads the byte at the PC into the instruction register and raises the PC by one.
- R3: add (0100), sub (0110) and nand (1000) write rx op ry into rx and take 4 cycles. sub computes rx minus ry, modulo 256.
- R4: Z and N are loaded from the result (Z = result is zero, N = result bit 7) only by add, sub, nand, shift and ori. Load, store, branches and the post-increment load leave them unchanged.
- R5: A shift is encoded as bits [2:0]=011, with rx in [7:6], direction in bit 5 (1 = left, 0 = logical right) and amount 0..3 in bits [4:3]. It writes the shifted rx back to rx and takes 4 cycles.
- R6: An ori is encoded as bits [2:0]=111 with a 5-bit unsigned constant in [7:3]. It sets r1 = r1 OR the zero-extended constant and takes 5 cycles.
- R7: load (0000) writes the byte at address ry into rx and takes 4 cycles. store (0010) writes rx to the byte at address ry and takes 3 cycles.
- R8: Branches carry a signed 4-bit offset in [7:4]. bz (0101) is taken when Z=1, bnz (1001) when Z=0 and bpz (1101) when N=0. A taken branch sets PC = branch address + 1 + offset; otherwise the PC is the branch address + 1. A branch always takes 3 cycles and leaves registers and flags unchanged.
- R9: The post-increment load (1100) writes the byte at address ry into rx, then writes the original ry + 1 into ry, over 5 cycles. When rx and ry are the same register, the incremented address is the final value.
- R10: Opcodes 0001, 1010 and 1110 finish in 2 cycles and change nothing except the PC advance from fetch.
- R11: instr_done is high for exactly the last cycle of each instruction. The cycle after it is always a fetch.
- R12: On a rising clock edge with ld_we high, the memory byte at ld_addr takes ld_data. peek_data shows the memory byte at peek_addr without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | 8 | Preload write address |
| ld_data | input | 8 | Preload write data |
| peek_addr | input | 8 | Memory observation address |
| peek_data | output | 8 | Memory byte at peek_addr |
| dbg_state | output | 4 | Controller state code |
| dbg_pc | output | 8 | Program counter |
| dbg_regs | output | 32 | r0..r3, r0 in bits [7:0] |
| dbg_z | output | 1 | Zero flag |
| dbg_n | output | 1 | Negative flag |
| instr_done | output | 1 | High in the last cycle of an instruction |

## Verification
The bench measures every instruction class's cycle count between fetch and the done pulse. A controller that skips or adds a state would report 3 where 4 is expected, or would lose the fifth step of ori or of the post-increment load. Branches are run forward and backward, taken and not taken, under each flag condition. An offset that is not sign-extended, or added to the wrong PC, lands on a spoiler byte instead of the target. The flag checks look for a load that disturbs Z, and the post-increment load with rx equal to ry tells apart the two possible orders of the register writes. Undefined opcodes must finish in two cycles with registers, flags and memory untouched.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int NREG = 4;
    localparam int RW   = $clog2(NREG);
    localparam int SW   = 4;

    localparam logic [3:0] OP_LOAD  = 4'b0000;
    localparam logic [3:0] OP_STORE = 4'b0010;
    localparam logic [3:0] OP_ADD   = 4'b0100;
    localparam logic [3:0] OP_SUB   = 4'b0110;
    localparam logic [3:0] OP_NAND  = 4'b1000;
    localparam logic [3:0] OP_LDPI  = 4'b1100;
    localparam logic [3:0] OP_BZ    = 4'b0101;
    localparam logic [3:0] OP_BNZ   = 4'b1001;
    localparam logic [3:0] OP_BPZ   = 4'b1101;
    localparam logic [2:0] OP_SHF3  = 3'b011;
    localparam logic [2:0] OP_ORI3  = 3'b111;

    typedef enum logic [SW-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ALU_EX = 4'd2,
        ST_ALU_WB = 4'd3,
        ST_ORI_RD = 4'd4,
        ST_ORI_EX = 4'd5,
        ST_ORI_WB = 4'd6,
        ST_LD_MEM = 4'd7,
        ST_LD_WB  = 4'd8,
        ST_LD_INC = 4'd9,
        ST_ST_MEM = 4'd10,
        ST_BRANCH = 4'd11
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_OR, ALU_NAND, ALU_SHF
    } alu_op_e;

    typedef enum logic [1:0] { A_PC, A_OPA, A_OPB } asel_e;

    typedef enum logic [2:0] {
        B_ONE, B_OPB, B_IMM3, B_IMM5, B_IMM4
    } bsel_e;

    typedef enum logic [1:0] { W_RX, W_RY, W_R1 } wsel_e;

    typedef enum logic [1:0] { S_ALUOUT, S_MDR, S_ALU } wsrc_e;

    typedef struct packed {
        logic    addr_pc;
        logic    ir_we;
        logic    pc_we;
        logic    opa_we;
        logic    opb_we;
        logic    opa_r1;
        logic    mdr_we;
        logic    aluout_we;
        logic    flags_we;
        logic    rf_we;
        wsel_e   wsel;
        wsrc_e   wsrc;
        logic    mem_we;
        asel_e   asel;
        bsel_e   bsel;
        alu_op_e op;
        logic    done;
    } ctrl_t;

endpackage

// File: rtl/mc8_alu.sv
module mc8_alu
    import mc8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_OR:   y = a | b;
            ALU_NAND: y = ~(a & b);
            ALU_SHF:  y = b[2] ? (a << b[1:0]) : (a >> b[1:0]);
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/mc8_regfile.sv
module mc8_regfile
    import mc8_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG,
    localparam int AB = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AB-1:0]  raddr_a,
    input  logic [AB-1:0]  raddr_b,
    output logic [W-1:0]   rdata_a,
    output logic [W-1:0]   rdata_b,
    input  logic           we,
    input  logic [AB-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] dump
);

    logic [W-1:0] regs_q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (we && waddr == AB'(g)) reg_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
        assign dump[g*W +: W] = regs_q[g];
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/mc8_mem.sv
module mc8_mem
    import mc8_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW,
    localparam int DEPTH = 1 << A
) (
    input  logic         clk,
    input  logic         we,
    input  logic [A-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [A-1:0] raddr,
    output logic [W-1:0] rdata,
    input  logic [A-1:0] paddr,
    output logic [W-1:0] pdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
    assign pdata = mem_q[paddr];

endmodule

// File: rtl/mc8_ctrl.sv
module mc8_ctrl
    import mc8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] opc,
    input  logic       z,
    input  logic       n,
    output ctrl_t      c,
    output state_e     state
);

    state_e state_d, state_q;
    logic   is_shf, is_ori, take;

    assign is_shf = (opc[2:0] == OP_SHF3);
    assign is_ori = (opc[2:0] == OP_ORI3);

    always_comb begin
        unique case (opc)
            OP_BZ:   take = z;
            OP_BNZ:  take = !z;
            OP_BPZ:  take = !n;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        c       = '0;
        c.asel  = A_OPA;
        c.bsel  = B_OPB;
        c.op    = ALU_ADD;
        c.wsel  = W_RX;
        c.wsrc  = S_ALUOUT;
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                c.addr_pc = 1'b1;
                c.ir_we   = 1'b1;
                c.pc_we   = 1'b1;
                c.asel    = A_PC;
                c.bsel    = B_ONE;
                state_d   = ST_DECODE;
            end
            ST_DECODE: begin
                c.opa_we = 1'b1;
                c.opb_we = 1'b1;
                if (is_shf) state_d = ST_ALU_EX;
                else if (is_ori) state_d = ST_ORI_RD;
                else begin
                    unique case (opc)
                        OP_ADD, OP_SUB, OP_NAND:  state_d = ST_ALU_EX;
                        OP_LOAD, OP_LDPI:         state_d = ST_LD_MEM;
                        OP_STORE:                 state_d = ST_ST_MEM;
                        OP_BZ, OP_BNZ, OP_BPZ:    state_d = ST_BRANCH;
                        default: begin
                            c.done  = 1'b1;
                            state_d = ST_FETCH;
                        end
                    endcase
                end
            end
            ST_ALU_EX: begin
                c.aluout_we = 1'b1;
                c.flags_we  = 1'b1;
                if (is_shf) begin
                    c.bsel = B_IMM3;
                    c.op   = ALU_SHF;
                end else begin
                    unique case (opc)
                        OP_SUB:  c.op = ALU_SUB;
                        OP_NAND: c.op = ALU_NAND;
                        default: c.op = ALU_ADD;
                    endcase
                end
                state_d = ST_ALU_WB;
            end
            ST_ALU_WB: begin
                c.rf_we = 1'b1;
                c.done  = 1'b1;
                state_d = ST_FETCH;
            end
            ST_ORI_RD: begin
                c.opa_we = 1'b1;
                c.opa_r1 = 1'b1;
                state_d  = ST_ORI_EX;
            end
            ST_ORI_EX: begin
                c.aluout_we = 1'b1;
                c.flags_we  = 1'b1;
                c.bsel      = B_IMM5;
                c.op        = ALU_OR;
                state_d     = ST_ORI_WB;
            end
            ST_ORI_WB: begin
                c.rf_we = 1'b1;
                c.wsel  = W_R1;
                c.done  = 1'b1;
                state_d = ST_FETCH;
            end
            ST_LD_MEM: begin
                c.mdr_we = 1'b1;
                state_d  = ST_LD_WB;
            end
            ST_LD_WB: begin
                c.rf_we = 1'b1;
                c.wsrc  = S_MDR;
                if (opc == OP_LDPI) state_d = ST_LD_INC;
                else begin
                    c.done  = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_LD_INC: begin
                c.rf_we = 1'b1;
                c.wsel  = W_RY;
                c.wsrc  = S_ALU;
                c.asel  = A_OPB;
                c.bsel  = B_ONE;
                c.done  = 1'b1;
                state_d = ST_FETCH;
            end
            ST_ST_MEM: begin
                c.mem_we = 1'b1;
                c.done   = 1'b1;
                state_d  = ST_FETCH;
            end
            ST_BRANCH: begin
                c.asel  = A_PC;
                c.bsel  = B_IMM4;
                c.pc_we = take;
                c.done  = 1'b1;
                state_d = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/mc8_core.sv
module mc8_core
    import mc8_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [AW-1:0]      ld_addr,
    input  logic [DW-1:0]      ld_data,
    input  logic [AW-1:0]      peek_addr,
    output logic [DW-1:0]      peek_data,
    output logic [SW-1:0]      dbg_state,
    output logic [AW-1:0]      dbg_pc,
    output logic [NREG*DW-1:0] dbg_regs,
    output logic               dbg_z,
    output logic               dbg_n,
    output logic               instr_done
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] mdr;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] aluout;
        logic          z;
        logic          n;
    } dp_t;

    dp_t    dp_d, dp_q;
    ctrl_t  c;
    state_e state;

    logic [RW-1:0] rx, ry, raddr_a, waddr;
    logic [DW-1:0] rf_a, rf_b, rf_wdata;
    logic [DW-1:0] alu_a, alu_b, alu_y;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic          mem_we;

    assign rx = dp_q.ir[7:6];
    assign ry = dp_q.ir[5:4];

    mc8_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .opc   (dp_q.ir[3:0]),
        .z     (dp_q.z),
        .n     (dp_q.n),
        .c     (c),
        .state (state)
    );

    assign raddr_a = c.opa_r1 ? RW'(1) : rx;

    always_comb begin
        unique case (c.wsel)
            W_RY:    waddr = ry;
            W_R1:    waddr = RW'(1);
            default: waddr = rx;
        endcase
        unique case (c.wsrc)
            S_MDR:   rf_wdata = dp_q.mdr;
            S_ALU:   rf_wdata = alu_y;
            default: rf_wdata = dp_q.aluout;
        endcase
    end

    mc8_regfile #(.W(DW), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (raddr_a),
        .raddr_b (ry),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .we      (c.rf_we),
        .waddr   (waddr),
        .wdata   (rf_wdata),
        .dump    (dbg_regs)
    );

    always_comb begin
        unique case (c.asel)
            A_PC:    alu_a = dp_q.pc;
            A_OPB:   alu_a = dp_q.opb;
            default: alu_a = dp_q.opa;
        endcase
        unique case (c.bsel)
            B_ONE:   alu_b = DW'(1);
            B_IMM3:  alu_b = {5'b0, dp_q.ir[5:3]};
            B_IMM5:  alu_b = {3'b0, dp_q.ir[7:3]};
            B_IMM4:  alu_b = {{4{dp_q.ir[7]}}, dp_q.ir[7:4]};
            default: alu_b = dp_q.opb;
        endcase
    end

    mc8_alu #(.W(DW)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (c.op),
        .y  (alu_y)
    );

    assign mem_raddr = c.addr_pc ? dp_q.pc : dp_q.opb;
    assign mem_we    = c.mem_we | ld_we;
    assign mem_waddr = c.mem_we ? dp_q.opb : ld_addr;
    assign mem_wdata = c.mem_we ? dp_q.opa : ld_data;

    mc8_mem #(.W(DW), .A(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    always_comb begin
        dp_d = dp_q;
        if (c.ir_we)     dp_d.ir     = mem_rdata;
        if (c.pc_we)     dp_d.pc     = alu_y;
        if (c.opa_we)    dp_d.opa    = rf_a;
        if (c.opb_we)    dp_d.opb    = rf_b;
        if (c.mdr_we)    dp_d.mdr    = mem_rdata;
        if (c.aluout_we) dp_d.aluout = alu_y;
        if (c.aluout_we && c.flags_we) begin
            dp_d.z = (alu_y == '0);
            dp_d.n = alu_y[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q    <= '0;
            dp_q.pc <= RESET_PC;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign dbg_state  = state;
    assign dbg_pc     = dp_q.pc;
    assign dbg_z      = dp_q.z;
    assign dbg_n      = dp_q.n;
    assign instr_done = c.done;

endmodule

// File: rtl/mc8_core_chk.sv
module mc8_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  state,
    input logic [7:0]  pc,
    input logic [31:0] regs,
    input logic        done
);

    assert_state_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 4'd11);

    assert_fetch_steps_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd0) |=> (pc == $past(pc) + 8'd1));

    assert_branch_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd11) |=> $stable(regs));

    assert_done_then_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == 4'd0));

    assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fetch_never_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd0) |-> !done);

endmodule

bind mc8_core mc8_core_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .state (dbg_state),
    .pc    (dbg_pc),
    .regs  (dbg_regs),
    .done  (instr_done)
);

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [7:0]  peek_addr = '0;
    logic [7:0]  peek_data;
    logic [3:0]  dbg_state;
    logic [7:0]  dbg_pc;
    logic [31:0] dbg_regs;
    logic        dbg_z, dbg_n, instr_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mc8_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data),
        .dbg_state  (dbg_state),
        .dbg_pc     (dbg_pc),
        .dbg_regs   (dbg_regs),
        .dbg_z      (dbg_z),
        .dbg_n      (dbg_n),
        .instr_done (instr_done)
    );

    localparam logic [3:0] C_LD = 4'b0000, C_ST = 4'b0010, C_ADD = 4'b0100,
                           C_SUB = 4'b0110, C_NAND = 4'b1000, C_LDPI = 4'b1100,
                           C_BZ = 4'b0101, C_BNZ = 4'b1001, C_BPZ = 4'b1101;

    function automatic logic [7:0] rr(input logic [3:0] op, input int a, input int b);
        return {a[1:0], b[1:0], op};
    endfunction
    function automatic logic [7:0] shf(input int a, input logic left, input int amt);
        return {a[1:0], left, amt[1:0], 3'b011};
    endfunction
    function automatic logic [7:0] ori(input int imm);
        return {imm[4:0], 3'b111};
    endfunction
    function automatic logic [7:0] br(input logic [3:0] op, input int off);
        return {off[3:0], op};
    endfunction

    function automatic logic [7:0] rg(input int i);
        return dbg_regs[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic begin_reset();
        @(negedge clk);
        rst_n = 1'b0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic end_reset();
        ld_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one instruction from its fetch cycle; returns at mid-cycle of the next fetch.
    task automatic run(input string req, input int exp_cyc);
        int cyc = 0;
        for (int i = 1; i <= 16; i++) begin
            if (instr_done) begin
                cyc = i;
                break;
            end
            @(negedge clk);
        end
        chk(req, "cycle count", cyc, exp_cyc);
        @(negedge clk);
    endtask

    task automatic t_alu();
        begin_reset();
        poke(8'h05, 8'h30);
        poke(8'h07, 8'h12);
        poke(8'h80, ori(5));
        poke(8'h81, rr(C_LD, 2, 1));
        poke(8'h82, ori(2));
        poke(8'h83, rr(C_LD, 3, 1));
        poke(8'h84, rr(C_ADD, 2, 3));
        poke(8'h85, rr(C_SUB, 3, 2));
        poke(8'h86, rr(C_NAND, 2, 2));
        poke(8'h87, rr(C_SUB, 0, 0));
        poke(8'h88, rr(C_LD, 2, 1));
        end_reset();
        peek_addr = 8'h80;
        #0.5;
        chk("R12", "preloaded byte", peek_data, ori(5));
        run("R6", 5);  chk("R6", "r1 after ori", rg(1), 8'h05);
        run("R7", 4);  chk("R7", "r2 after load", rg(2), 8'h30);
        run("R6", 5);  chk("R6", "r1 or 2", rg(1), 8'h07);
        run("R7", 4);  chk("R7", "r3 after load", rg(3), 8'h12);
        run("R3", 4);  chk("R3", "add result", rg(2), 8'h42);
        chk("R4", "z n after add", {dbg_z, dbg_n}, 2'b00);
        run("R3", 4);  chk("R3", "sub result", rg(3), 8'hD0);
        chk("R4", "z n after sub", {dbg_z, dbg_n}, 2'b01);
        run("R3", 4);  chk("R3", "nand result", rg(2), 8'hBD);
        run("R3", 4);  chk("R3", "sub to zero", rg(0), 8'h00);
        chk("R4", "z n on zero", {dbg_z, dbg_n}, 2'b10);
        run("R7", 4);  chk("R7", "reload r2", rg(2), 8'h12);
        chk("R4", "load keeps flags", {dbg_z, dbg_n}, 2'b10);
        chk("R2", "pc after nine", dbg_pc, 8'h89);
    endtask

    task automatic t_reset();
        begin_reset();
        end_reset();
        chk("R1", "pc", dbg_pc, 8'h80);
        chk("R1", "state", dbg_state, 4'd0);
        chk("R1", "regs", dbg_regs, 32'h0);
        chk("R1", "flags", {dbg_z, dbg_n}, 2'b00);
        chk("R11", "no done in fetch", instr_done, 1'b0);
    endtask

    task automatic t_shift();
        begin_reset();
        poke(8'h80, ori(5'h13));
        poke(8'h81, shf(1, 1'b1, 2));
        poke(8'h82, shf(1, 1'b0, 3));
        poke(8'h83, shf(1, 1'b1, 3));
        poke(8'h84, shf(1, 1'b0, 0));
        end_reset();
        run("R6", 5);
        run("R5", 4);  chk("R5", "left by 2", rg(1), 8'h4C);
        run("R5", 4);  chk("R5", "right by 3", rg(1), 8'h09);
        run("R5", 4);  chk("R5", "left by 3", rg(1), 8'h48);
        chk("R4", "z n after shift", {dbg_z, dbg_n}, 2'b00);
        run("R5", 4);  chk("R5", "right by 0", rg(1), 8'h48);
    endtask

    task automatic t_store();
        begin_reset();
        poke(8'h09, 8'hEE);
        poke(8'h00, 8'hEE);
        poke(8'h80, ori(9));
        poke(8'h81, rr(C_ST, 1, 1));
        poke(8'h82, ori(5'h16));
        poke(8'h83, rr(C_ST, 1, 0));
        end_reset();
        run("R6", 5);
        run("R7", 3);
        peek_addr = 8'h09; #0.5;
        chk("R7", "store to r1 address", peek_data, 8'h09);
        run("R6", 5);
        chk("R6", "r1 or 0x16", rg(1), 8'h1F);
        run("R7", 3);
        peek_addr = 8'h00; #0.5;
        chk("R7", "store to r0 address", peek_data, 8'h1F);
        chk("R7", "store keeps regs", rg(1), 8'h1F);
    endtask

    task automatic t_branch();
        begin_reset();
        poke(8'h80, ori(0));
        poke(8'h81, br(C_BZ, 2));
        poke(8'h82, ori(31));
        poke(8'h83, ori(31));
        poke(8'h84, br(C_BNZ, 3));
        poke(8'h85, ori(5'h10));
        poke(8'h86, br(C_BPZ, 1));
        poke(8'h87, ori(1));
        poke(8'h88, br(C_BNZ, 1));
        poke(8'h89, ori(2));
        poke(8'h8A, rr(C_NAND, 1, 1));
        poke(8'h8B, br(C_BPZ, 2));
        poke(8'h8C, br(C_BZ, 2));
        poke(8'h8D, br(C_BNZ, -4));
        end_reset();
        run("R6", 5);
        chk("R4", "ori zero flag", {dbg_z, dbg_n}, 2'b10);
        run("R8", 3);  chk("R8", "bz taken", dbg_pc, 8'h84);
        run("R8", 3);  chk("R8", "bnz not taken", dbg_pc, 8'h85);
        chk("R8", "flags kept", {dbg_z, dbg_n}, 2'b10);
        run("R6", 5);
        run("R8", 3);  chk("R8", "bpz taken", dbg_pc, 8'h88);
        run("R8", 3);  chk("R8", "bnz taken", dbg_pc, 8'h8A);
        chk("R8", "r1 untouched", rg(1), 8'h10);
        run("R3", 4);  chk("R4", "nand negative", {dbg_z, dbg_n}, 2'b01);
        run("R8", 3);  chk("R8", "bpz not taken", dbg_pc, 8'h8C);
        run("R8", 3);  chk("R8", "bz not taken", dbg_pc, 8'h8D);
        run("R8", 3);  chk("R8", "backward bnz", dbg_pc, 8'h8A);
        chk("R8", "r1 after branches", rg(1), 8'hEF);
    endtask

    task automatic t_ldpi();
        begin_reset();
        poke(8'h04, 8'h77);
        poke(8'h05, 8'h55);
        poke(8'h80, ori(4));
        poke(8'h81, rr(C_LDPI, 2, 1));
        poke(8'h82, rr(C_LDPI, 1, 1));
        end_reset();
        run("R6", 5);
        run("R9", 5);
        chk("R9", "loaded rx", rg(2), 8'h77);
        chk("R9", "incremented ry", rg(1), 8'h05);
        chk("R4", "ldpi keeps flags", {dbg_z, dbg_n}, 2'b00);
        run("R9", 5);
        chk("R9", "same reg ends incremented", rg(1), 8'h06);
    endtask

    task automatic t_undef();
        begin_reset();
        poke(8'h03, 8'hA5);
        poke(8'h80, ori(3));
        poke(8'h81, rr(4'b0001, 0, 1));
        poke(8'h82, rr(4'b1010, 1, 1));
        poke(8'h83, rr(4'b1110, 2, 1));
        end_reset();
        run("R6", 5);
        run("R10", 2);
        run("R10", 2);
        run("R10", 2);
        chk("R10", "pc", dbg_pc, 8'h84);
        chk("R10", "regs", dbg_regs, 32'h0000_0300);
        chk("R10", "flags", {dbg_z, dbg_n}, 2'b00);
        peek_addr = 8'h03; #0.5;
        chk("R10", "memory", peek_data, 8'hA5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_reset();
        t_shift();
        t_store();
        t_branch();
        t_ldpi();
        t_undef();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule